// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block holds the per-channel transfer registers of a four-channel DMA controller and exposes them through an 8-bit I/O port window. Each channel keeps a 16-bit starting address and a 16-bit transfer length, both loaded by software, together with a working address and a progress counter. Software moves these 16-bit values one byte per access. A single byte-pointer flip-flop, shared by all channels, picks the byte for each access and flips after every access.

Writing the upper byte of either 16-bit value re-arms the channel: the working address is loaded from the starting address, scaled by the word shift, and the progress counter returns to zero. The service engine advances the progress counter with one strobe per transfer. Reads return values adjusted by that progress, not the stored values. An address read returns the working address moved forward or back by the progress, depending on the channel's direction input. A length read returns how much of the transfer is left. The `WORD_SHIFT` parameter is 0 for a byte-wide controller and 1 for a word-wide one. It scales both the port decode and the readback.

Top module: `dma_chan_regs`

## Requirements
- R1: The port offset is `port_addr >> WORD_SHIFT`, a 3-bit value. Offset bits [2:1] give the channel number. Offset bit 0 chooses the address register (0) or the count register (1).
- R2: The byte pointer resets to 0 and flips after every cycle with `wr_en` or `rd_en` high. When `ptr_clr` is high it goes to 0 instead, and the clear wins over the flip.
- R3: A write while the pointer is 0 replaces bits [7:0] of the selected starting register. It leaves bits [15:8] and the channel's working registers unchanged. A write while the pointer is 1 replaces bits [15:8].
- R4: A write while the pointer is 1 also loads the working address with the newly written starting address shifted left by `WORD_SHIFT`, and clears the progress counter to 0.
- R5: A count read yields `(base_count << WORD_SHIFT) - progress`, taken modulo 2^(18+WORD_SHIFT).
- R6: An address read yields `working_address + progress` when the channel's `dir_dec` bit is 0. It yields `working_address - progress` when that bit is 1.
- R7: The byte returned is bits [7:0] of the read value shifted right by `WORD_SHIFT`, plus 8 more bits when the pointer is 1.
- R8: A high `cnt_inc[i]` adds 1 to channel i's progress counter, and the next read shows the new value. A reload (R4) on the same channel in the same cycle wins over the increment.
- R9: After reset, every starting, working and progress register is 0, so every readback is 0.
- R10: `rd_data` is 0 in any cycle with `rd_en` low. When `rd_en` is high it reflects the registers as they stood before that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_addr | input | 3+WORD_SHIFT | Port offset within the channel window |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte (combinational) |
| ptr_clr | input | 1 | Forces the byte pointer to 0 |
| dir_dec | input | 4 | Per-channel decrement-direction bit from the mode register |
| cnt_inc | input | 4 | Per-channel progress increment strobes |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `cnt_inc` strobes come one per channel per cycle. The stimulus keeps to this: each vector is either a write, a read, or neither. The progress counters are allowed to wrap, and the reference model wraps them at the same width as the design. The shift in the port decode is exercised by running the bench with the word-wide setting, so the ignored low address bit is toggled at random.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);

    typedef enum logic {
        SEL_ADDR  = 1'b0,
        SEL_COUNT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        reg_sel_e        sel;
    } port_dec_t;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
    import dma_regs_pkg::*;
#(
    parameter int WORD_SHIFT = 0,
    localparam int PA_W = 3 + WORD_SHIFT
) (
    input  logic [PA_W-1:0] port_addr,
    output port_dec_t       dec
);
    logic [2:0] offset;

    always_comb begin
        offset   = 3'(port_addr >> WORD_SHIFT);
        dec.chan = offset[2:1];
        dec.sel  = reg_sel_e'(offset[0]);
    end
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_regs_pkg::*;
#(
    parameter int WORD_SHIFT = 0,
    localparam int AW = 16 + WORD_SHIFT,
    localparam int CW = 17 + WORD_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  reg_sel_e      sel,
    input  logic [7:0]    wr_data,
    input  logic          inc,
    output logic [15:0]   base_a,
    output logic [15:0]   base_c,
    output logic [AW-1:0] cur_a,
    output logic [CW-1:0] cur_c
);
    typedef struct packed {
        logic [15:0]   base_a;
        logic [15:0]   base_c;
        logic [AW-1:0] cur_a;
        logic [CW-1:0] cur_c;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_lo) begin
            if (sel == SEL_ADDR) slot_d.base_a[7:0] = wr_data;
            else                 slot_d.base_c[7:0] = wr_data;
        end
        if (wr_hi) begin
            if (sel == SEL_ADDR) slot_d.base_a[15:8] = wr_data;
            else                 slot_d.base_c[15:8] = wr_data;
            slot_d.cur_a = AW'(slot_d.base_a) << WORD_SHIFT;
            slot_d.cur_c = '0;
        end else if (inc) begin
            slot_d.cur_c = slot_q.cur_c + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign base_a = slot_q.base_a;
    assign base_c = slot_q.base_c;
    assign cur_a  = slot_q.cur_a;
    assign cur_c  = slot_q.cur_c;

    AST_RELOAD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> cur_c == '0); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_hi) |=> cur_c == $past(cur_c) + 1'b1); // R8
    AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (base_a[15:8] == $past(base_a[15:8])) && (base_c[15:8] == $past(base_c[15:8]))); // R3
    AST_LOW_WRITE_KEEPS_WORKING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !inc) |=> $stable(cur_a) && $stable(cur_c)); // R3
endmodule

// File: rtl/dma_readback.sv
module dma_readback
    import dma_regs_pkg::*;
#(
    parameter int WORD_SHIFT = 0,
    localparam int AW = 16 + WORD_SHIFT,
    localparam int CW = 17 + WORD_SHIFT,
    localparam int VW = 18 + WORD_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  reg_sel_e      sel,
    input  logic          ptr,
    input  logic          dir,
    input  logic [15:0]   base_c,
    input  logic [AW-1:0] cur_a,
    input  logic [CW-1:0] cur_c,
    output logic [7:0]    rd_byte
);
    logic [VW-1:0] val;
    logic [VW-1:0] shifted;
    logic [4:0]    sh;

    always_comb begin
        if (sel == SEL_COUNT)
            val = (VW'(base_c) << WORD_SHIFT) - VW'(cur_c);
        else if (dir)
            val = VW'(cur_a) - VW'(cur_c);
        else
            val = VW'(cur_a) + VW'(cur_c);
        sh      = 5'(WORD_SHIFT) + (ptr ? 5'd8 : 5'd0);
        shifted = val >> sh;
        rd_byte = rd_en ? shifted[7:0] : 8'h00;
    end

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_byte == 8'h00); // R10
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int WORD_SHIFT = 0,
    localparam int PA_W = 3 + WORD_SHIFT,
    localparam int AW   = 16 + WORD_SHIFT,
    localparam int CW   = 17 + WORD_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-1:0]   port_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              ptr_clr,
    input  logic [NUM_CH-1:0] dir_dec,
    input  logic [NUM_CH-1:0] cnt_inc
);
    typedef struct packed {
        logic ptr;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    port_dec_t dec;

    logic [15:0]   base_a_arr [NUM_CH];
    logic [15:0]   base_c_arr [NUM_CH];
    logic [AW-1:0] cur_a_arr  [NUM_CH];
    logic [CW-1:0] cur_c_arr  [NUM_CH];

    always_comb begin
        ctl_d = ctl_q;
        if (ptr_clr)               ctl_d.ptr = 1'b0;
        else if (wr_en || rd_en)   ctl_d.ptr = ~ctl_q.ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    dma_port_decode #(.WORD_SHIFT(WORD_SHIFT)) u_dec (
        .port_addr (port_addr),
        .dec       (dec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (dec.chan == CH_W'(i));
        dma_chan_slot #(.WORD_SHIFT(WORD_SHIFT)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (hit && !ctl_q.ptr),
            .wr_hi   (hit && ctl_q.ptr),
            .sel     (dec.sel),
            .wr_data (wr_data),
            .inc     (cnt_inc[i]),
            .base_a  (base_a_arr[i]),
            .base_c  (base_c_arr[i]),
            .cur_a   (cur_a_arr[i]),
            .cur_c   (cur_c_arr[i])
        );
    end

    dma_readback #(.WORD_SHIFT(WORD_SHIFT)) u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (dec.sel),
        .ptr     (ctl_q.ptr),
        .dir     (dir_dec[dec.chan]),
        .base_c  (base_c_arr[dec.chan]),
        .cur_a   (cur_a_arr[dec.chan]),
        .cur_c   (cur_c_arr[dec.chan]),
        .rd_byte (rd_data)
    );

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> !ctl_q.ptr); // R2
    AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !ptr_clr) |=> ctl_q.ptr != $past(ctl_q.ptr)); // R2
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en && !ptr_clr) |=> $stable(ctl_q.ptr)); // R2
endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
    localparam int PERIOD = 10;
    localparam int WS     = 1;
    localparam int PA_W   = 3 + WS;
    localparam int AMASK  = (1 << (16 + WS)) - 1;
    localparam int CMASK  = (1 << (17 + WS)) - 1;
    localparam int VMASK  = (1 << (18 + WS)) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PA_W-1:0] port_addr = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [7:0]      wr_data = '0;
    logic [7:0]      rd_data;
    logic            ptr_clr = 1'b0;
    logic [3:0]      dir_dec = '0;
    logic [3:0]      cnt_inc = '0;

    int vectors = 0;
    int fails   = 0;
    string req  = "R9";

    // reference model state
    int m_ba [4];
    int m_bc [4];
    int m_ca [4];
    int m_cc [4];
    int m_ptr;

    dma_chan_regs #(.WORD_SHIFT(WS)) dut (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .ptr_clr(ptr_clr),
        .dir_dec(dir_dec), .cnt_inc(cnt_inc)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int expect_byte();
        int off, ch, val;
        if (!rd_en) return 0;
        off = (int'(port_addr) >> WS) & 7;
        ch  = off >> 1;
        if (off & 1) val = ((m_bc[ch] << WS) - m_cc[ch]) & VMASK;
        else if (dir_dec[ch]) val = (m_ca[ch] - m_cc[ch]) & VMASK;
        else val = (m_ca[ch] + m_cc[ch]) & VMASK;
        return (val >> (WS + (m_ptr ? 8 : 0))) & 255;
    endfunction

    task automatic model_clock();
        int off, ch;
        off = (int'(port_addr) >> WS) & 7;
        ch  = off >> 1;
        for (int i = 0; i < 4; i++) begin
            if (cnt_inc[i] && !(wr_en && m_ptr == 1 && ch == i))
                m_cc[i] = (m_cc[i] + 1) & CMASK;
        end
        if (wr_en) begin
            if (m_ptr == 0) begin
                if (off & 1) m_bc[ch] = (m_bc[ch] & 'hff00) | int'(wr_data);
                else         m_ba[ch] = (m_ba[ch] & 'hff00) | int'(wr_data);
            end else begin
                if (off & 1) m_bc[ch] = (m_bc[ch] & 'hff) | (int'(wr_data) << 8);
                else         m_ba[ch] = (m_ba[ch] & 'hff) | (int'(wr_data) << 8);
                m_ca[ch] = (m_ba[ch] << WS) & AMASK;
                m_cc[ch] = 0;
            end
        end
        if (ptr_clr) m_ptr = 0;
        else if (wr_en || rd_en) m_ptr = 1 - m_ptr;
    endtask

    task automatic step(input bit w, input bit r, input int ch, input int sel,
                        input int data, input bit clr, input logic [3:0] inc);
        int exp_v;
        @(negedge clk);
        wr_en     = w;
        rd_en     = r;
        port_addr = PA_W'((((ch << 1) | sel) << WS) | ($urandom & ((1 << WS) - 1)));
        wr_data   = 8'(data);
        ptr_clr   = clr;
        cnt_inc   = inc;
        #1;
        exp_v = expect_byte();
        vectors++;
        if (int'(rd_data) != exp_v) begin
            fails++;
            $display("FAIL %s rd_data actual %02h expected %02h (ch %0d sel %0d ptr %0d)",
                     req, rd_data, exp_v, ch, sel, m_ptr);
        end
        model_clock();
    endtask

    task automatic wr16(input int ch, input int sel, input int v);
        step(1, 0, ch, sel, v & 255, 0, 4'b0);
        step(1, 0, ch, sel, (v >> 8) & 255, 0, 4'b0);
    endtask

    task automatic rd16(input int ch, input int sel);
        step(0, 1, ch, sel, 0, 0, 4'b0);
        step(0, 1, ch, sel, 0, 0, 4'b0);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state reads back as zero on every register
        req = "R9";
        for (int c = 0; c < 4; c++) begin
            rd16(c, 0);
            rd16(c, 1);
        end

        // R1 and R3: load each channel with distinct values, read them back
        req = "R1";
        for (int c = 0; c < 4; c++) begin
            wr16(c, 0, 'h1234 + c * 'h1111);
            wr16(c, 1, 'h0040 + c);
        end
        for (int c = 0; c < 4; c++) begin
            rd16(c, 0);
            rd16(c, 1);
        end

        // R3: a lone low byte write changes only bits 7:0
        req = "R3";
        step(1, 0, 2, 0, 'hA5, 0, 4'b0);
        step(1, 0, 1, 1, 'h00, 1, 4'b0);
        rd16(2, 0);

        // R2: clear returns the pointer to the low byte mid-sequence
        req = "R2";
        step(0, 1, 0, 0, 0, 0, 4'b0);
        step(0, 0, 0, 0, 0, 1, 4'b0);
        rd16(0, 0);
        step(0, 1, 3, 1, 0, 1, 4'b0);
        rd16(3, 1);

        // R8 and R5: progress strobes move the count readback
        req = "R8";
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, 0, 4'b0011);
        rd16(0, 1);
        rd16(1, 1);

        // R6: decrement direction moves the address readback down
        req = "R6";
        dir_dec = 4'b0001;
        rd16(0, 0);
        dir_dec = 4'b0000;
        rd16(0, 0);

        // R4: high byte write re-arms working registers; also wins over an increment
        req = "R4";
        step(1, 0, 1, 0, 'h77, 0, 4'b0010);
        step(1, 0, 1, 0, 'h88, 0, 4'b0010);
        rd16(1, 0);
        rd16(1, 1);

        // R5 and R7: count below progress wraps; byte selection with word shift
        req = "R5";
        wr16(3, 1, 'h0001);
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 0, 4'b1000);
        rd16(3, 1);
        req = "R7";
        wr16(2, 0, 'hFFFF);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 4'b0100);
        rd16(2, 0);

        // R10 plus mixed random traffic
        req = "R10";
        for (int n = 0; n < 4000; n++) begin
            int kind;
            kind = $urandom_range(0, 3);
            dir_dec = 4'($urandom);
            step(kind == 0, kind == 1, $urandom_range(0, 3), $urandom_range(0, 1),
                 $urandom_range(0, 255), ($urandom_range(0, 15) == 0), 4'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule